// File: doc/BRIEF.md
# Peg code guess scorer

This block scores one guess in a code-breaking game. A secret key and a guess each hold four pegs, and each peg is a 2-bit colour code. The block returns two counts. The black count is the number of pegs whose colour and position both match. The white count is the number of further pegs whose colour appears in the key at a different position.

Scoring is combinational. It compares the guess against rotated copies of the key. Positions already counted as black are masked out. Each key peg that gets used is then cleared, so a repeated colour can never be counted twice. A one-cycle start strobe loads the score into output registers and raises a valid flag for one cycle. Game sequencing, guess counting and display are handled elsewhere.

Top module: `peg_scorer`

## Requirements
- R1: Peg p (0 to 3) occupies bits [2p+1:2p] of `key` and of `guess`, so peg 0 is bits [1:0] and peg 3 is bits [7:6]. Each 2-bit value is one of four colours.
- R2: `black` equals the number of peg positions where the key and guess colours are equal.
- R3: `white` equals the sum over all colours of min(count in key, count in guess), minus `black`.
- R4: A position scored black takes no part in white matching, neither on the guess side nor on the key side.
- R5: Repeated colours in the key or in the guess are never counted more than once. Each key peg and each guess peg contributes to at most one match.
- R6: `black` + `white` never exceeds 4. Both counts are 3 bits wide.
- R7: On a rising clock edge where `start` is 1, the score of the `key` and `guess` present at that edge is registered. `valid` is then 1 for exactly the following cycle, and is 0 after any edge where `start` is 0.
- R8: While `start` is 0, `black` and `white` hold their last values, and changes on `key` or `guess` have no effect on them.
- R9: `black` is 4 exactly when `guess` equals `key`, and `white` is then 0.
- R10: While `rst_n` is 0 (asynchronous, active low), `valid`, `black` and `white` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Score strobe, sampled on the rising edge |
| key | input | 8 | Secret code, four 2-bit pegs |
| guess | input | 8 | Guess, four 2-bit pegs |
| valid | output | 1 | One-cycle flag marking a new score |
| black | output | 3 | Right colour in the right position |
| white | output | 3 | Right colour in the wrong position |

## Verification
The bench targets the following corner cases:

- A guess made of one repeated colour against a key that holds that colour once. This exposes a scorer that counts a key peg more than once; such a design reports whites above the true value or a total above four.
- Pairs where a black position shares its colour with other pegs. These expose a design that forgets to mask black positions and so counts the same peg as both black and white.
- Full permutations of the key, where every peg is white. These check that all three rotations take part.
- A stream of pseudo-random pairs compared against a colour-histogram model. This catches greedy masking that drops a valid match.
- Timing checks: the valid flag must fall after one cycle, and results must hold while the inputs change with no strobe. A design with the wrong capture timing fails these checks.

// File: rtl/peg_scorer.sv
module peg_scorer #(
  parameter int PEGS = 4,
  parameter int CW   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [PEGS*CW-1:0]            key,
  input  logic [PEGS*CW-1:0]            guess,
  output logic                          valid,
  output logic [$clog2(PEGS+1)-1:0]     black,
  output logic [$clog2(PEGS+1)-1:0]     white
);
  localparam int NW = $clog2(PEGS+1);

  logic [PEGS-1:0] hit, gfree, kfree;
  logic [NW-1:0]   bcnt, wcnt;

  always_comb begin
    bcnt = '0;
    wcnt = '0;
    for (int i = 0; i < PEGS; i++) begin
      hit[i] = (key[i*CW +: CW] == guess[i*CW +: CW]);
      if (hit[i]) bcnt = bcnt + NW'(1);
    end
    gfree = ~hit;
    kfree = ~hit;
    for (int r = 1; r < PEGS; r++) begin
      for (int i = 0; i < PEGS; i++) begin
        int j;
        j = (i + r) % PEGS;
        if (gfree[i] && kfree[j] && (guess[i*CW +: CW] == key[j*CW +: CW])) begin
          gfree[i] = 1'b0;
          kfree[j] = 1'b0;
          wcnt = wcnt + NW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      black <= '0;
      white <= '0;
    end else begin
      valid <= start;
      if (start) begin
        black <= bcnt;
        white <= wcnt;
      end
    end
  end
endmodule

// File: rtl/peg_scorer_chk.sv
module peg_scorer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] key,
  input logic [7:0] guess,
  input logic       valid,
  input logic [2:0] black,
  input logic [2:0] white
);
  assert_sum_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (4'(black) + 4'(white)) <= 4'd4);

  assert_valid_follows_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  assert_hold_without_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(black) && $stable(white)));

  assert_exact_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && key == guess) |=> (black == 3'd4 && white == 3'd0));

  assert_four_black_needs_equal_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && key != guess) |=> (black != 3'd4));
endmodule

bind peg_scorer peg_scorer_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .key(key), .guess(guess),
  .valid(valid), .black(black), .white(white)
);

// File: tb/test_peg_scorer.sv
module test_peg_scorer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] key = '0, guess = '0;
  logic       valid;
  logic [2:0] black, white;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  peg_scorer i_peg_scorer (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .guess(guess),
    .valid(valid), .black(black), .white(white)
  );

  // {key, guess, black, white}
  localparam logic [21:0] VEC [13] = '{
    {8'h1B, 8'h1B, 3'd4, 3'd0},
    {8'h1B, 8'hE4, 3'd0, 3'd4},
    {8'h00, 8'h55, 3'd0, 3'd0},
    {8'h00, 8'h01, 3'd3, 3'd0},
    {8'h05, 8'h50, 3'd0, 3'd4},
    {8'h1B, 8'hFF, 3'd1, 3'd0},
    {8'hFF, 8'h1B, 3'd1, 3'd0},
    {8'h1B, 8'h1E, 3'd2, 3'd2},
    {8'h0A, 8'hA5, 3'd0, 3'd2},
    {8'h36, 8'h9C, 3'd0, 3'd4},
    {8'h55, 8'h5A, 3'd2, 3'd0},
    {8'h6C, 8'h66, 3'd2, 3'd0},
    {8'hE4, 8'h1B, 3'd0, 3'd4}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void ref_score(input logic [7:0] k, input logic [7:0] g,
                                    output int b, output int w);
    int ck[4], cg[4], tot;
    b = 0; tot = 0;
    for (int c = 0; c < 4; c++) begin ck[c] = 0; cg[c] = 0; end
    for (int p = 0; p < 4; p++) begin
      if (k[2*p +: 2] == g[2*p +: 2]) b++;
      ck[k[2*p +: 2]]++;
      cg[g[2*p +: 2]]++;
    end
    for (int c = 0; c < 4; c++) tot += (ck[c] < cg[c]) ? ck[c] : cg[c];
    w = tot - b;
  endfunction

  task automatic score(input logic [7:0] k, input logic [7:0] g,
                       input int eb, input int ew, input string tag);
    @(negedge clk);
    key = k; guess = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R7 valid"}, valid, 1);
    check({tag, " R2 black"}, black, eb);
    check({tag, " R3 white"}, white, ew);
    check({tag, " R6 sum"}, int'(black) + int'(white) <= 4, 1);
    @(negedge clk);
    check({tag, " R7 valid drop"}, valid, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int b, w;
    repeat (3) @(negedge clk);
    // R10 reset state, even with start asserted
    start = 1'b1; key = 8'h1B; guess = 8'h1B;
    @(negedge clk);
    check("R10 valid", valid, 0);
    check("R10 black", black, 0);
    check("R10 white", white, 0);
    start = 1'b0;
    rst_n = 1'b1;

    // R1 R2 R3 R4 R5 R9 table
    for (int n = 0; n < 13; n++)
      score(VEC[n][21:14], VEC[n][13:6], int'(VEC[n][5:3]), int'(VEC[n][2:0]), "table");

    // R9: equality implies 4 black, 0 white
    score(8'hC3, 8'hC3, 4, 0, "R9 equal");
    score(8'hC3, 8'hC1, 3, 0, "R9 near");

    // R8: inputs change without start, outputs hold
    score(8'h1B, 8'h1E, 2, 2, "R8 setup");
    @(negedge clk);
    key = 8'h00; guess = 8'hFF;
    repeat (3) @(negedge clk);
    check("R8 hold black", black, 2);
    check("R8 hold white", white, 2);
    check("R8 valid low", valid, 0);

    // R7 back-to-back strobes
    @(negedge clk);
    key = 8'h55; guess = 8'h55; start = 1'b1;
    @(negedge clk);
    check("R7 b2b first", black, 4);
    key = 8'h00; guess = 8'h55;
    @(negedge clk);
    start = 1'b0;
    check("R7 b2b valid", valid, 1);
    check("R7 b2b second black", black, 0);
    check("R7 b2b second white", white, 0);
    @(negedge clk);

    // R3 R5 pseudo-random pairs against histogram model
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ref_score(lfsr[7:0], lfsr[15:8], b, w);
      score(lfsr[7:0], lfsr[15:8], b, w, "R5 random");
    end

    // R10 reset mid-run clears outputs
    score(8'h1B, 8'h1B, 4, 0, "R10 pre");
    rst_n = 1'b0;
    #1;
    check("R10 async black", black, 0);
    check("R10 async valid", valid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule